// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Read Controller

This block is the bus-facing front end of a small byte-addressed nonvolatile memory. It sits on a two-wire serial bus (clock line plus open-drain data line) and acts as a slave. Both bus lines are sampled through a synchronizer into the system clock domain. The block detects START and STOP conditions and checks the 7-bit device identifier in the first byte of each transfer. The bit after the identifier selects a read or a write. The data line is never driven high: the block only asserts a pull-low enable.

One address counter is shared by all transactions. A write transfer loads the counter from its word-address byte. A STOP right after that byte leaves only the new address behind. A repeated START followed by a read-mode identifier turns the same write phase into a random read. A read-mode identifier on its own reads from wherever the counter already points. Every byte that is read or written advances the counter, which wraps from the top address back to 0. The memory itself is reached through a synchronous read port that the counter addresses at all times, and through a write-request strobe with address and data. A STOP that closes a write transfer carrying at least one data byte raises a one-cycle pulse that starts the external nonvolatile cycle. While that cycle reports busy, the block refuses to acknowledge its identifier, so the master can poll until the cycle is complete.

Top module: `serial_mem_slave`

## Requirements
- R1: The identifier byte is acknowledged only when its upper 7 bits equal the DEV_ID parameter (0x50 by default). Any other identifier gets no acknowledge, and the block leaves the data line alone until the next START.
- R2: While nv_busy is high at the end of an identifier byte, that byte is not acknowledged, whether it selects a read or a write. Once nv_busy is low, the same identifier is acknowledged again.
- R3: When bit 0 of a matching identifier byte is 1 (read), the block acknowledges it and then sends 8 data bits, most significant bit first, taken from the memory word at the address counter.
- R4: After a byte at address n is read or written, the counter holds n+1. A read transfer with no preceding address phase therefore returns the word at n+1.
- R5: A write-mode identifier and one word-address byte, followed by a repeated START and a read-mode identifier, returns data starting at that word address.
- R6: A STOP directly after the word-address byte loads the counter and does nothing else: no write request and no nonvolatile-cycle pulse. The next plain read starts at the loaded address.
- R7: When the master pulls the data line low in the ninth clock of a read byte, the next sequential byte follows. When the master leaves the line high, the block stops driving and stays silent until the next START or STOP.
- R8: The counter rolls over from 2^ADDR_W-1 to 0 during sequential access.
- R9: In a write transfer, each data byte after the word address is acknowledged and raises wr_req for one cycle with wr_addr and wr_data, and the counter advances. A STOP after at least one such byte pulses nv_start for one cycle. A STOP without any data byte does not.
- R10: The pull-low enable changes only while the synchronized clock line is low.
- R11: After reset the data line is released, the address counter is 0, and no write request or nonvolatile-cycle pulse is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | Pull data line low when 1 |
| nv_busy | input | 1 | Nonvolatile write cycle in progress |
| mem_addr | output | ADDR_W | Read address to memory (current counter) |
| mem_rdata | input | 8 | Memory read data, valid one clock after mem_addr |
| wr_req | output | 1 | One-cycle write request strobe |
| wr_addr | output | ADDR_W | Address of the write request |
| wr_data | output | 8 | Data of the write request |
| nv_start | output | 1 | One-cycle pulse to start the nonvolatile cycle |

## Verification
Some rules are checked by assertions on every clock cycle. The pull-low enable changes only while the clock line is low. The counter moves only by a load or a single wrapping increment. A write request comes only out of the data-byte phase. A nonvolatile-cycle pulse comes only from a STOP. No acknowledge is given to an identifier while the busy input is high. The bench scenarios are needed for the rest. They show the data returned by current, random and sequential reads, including rollover at the top address. They show that set-address issues no writes and that a NACK from the master silences the slave. They show that a polled busy period ends in a normal acknowledge.

// File: rtl/sms_pkg.sv
package sms_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WADR,
    ST_WADR_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_RDAT,
    ST_RACK,
    ST_HOLD
  } sms_state_e;
endpackage

// File: rtl/sms_line_sync.sv
module sms_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic ev_start,
  output logic ev_stop
);
  // STAGES synchronizer flops plus one history flop per line
  logic [STAGES:0] scl_sh;
  logic [STAGES:0] sda_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[STAGES-1:0], scl_i};
      sda_sh <= {sda_sh[STAGES-1:0], sda_i};
    end
  end

  assign scl_lvl  = scl_sh[STAGES-1];
  assign sda_lvl  = sda_sh[STAGES-1];
  assign scl_rise = scl_sh[STAGES-1] & ~scl_sh[STAGES];
  assign scl_fall = ~scl_sh[STAGES-1] & scl_sh[STAGES];
  assign ev_start = scl_sh[STAGES-1] & scl_sh[STAGES] & sda_sh[STAGES] & ~sda_sh[STAGES-1];
  assign ev_stop  = scl_sh[STAGES-1] & scl_sh[STAGES] & ~sda_sh[STAGES] & sda_sh[STAGES-1];
endmodule

// File: rtl/sms_shift8.sv
module sms_shift8 #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic         shift_en,
  input  logic         shift_in,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (load_en)       q_d = load_val;
    else if (shift_en) q_d = {q[W-2:0], shift_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (load_en || shift_en) q <= q_d;
  end
endmodule

// File: rtl/sms_addr_ctr.sv
module sms_addr_ctr #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              inc,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    addr_d = addr;
    if (load)     addr_d = load_val;
    else if (inc) addr_d = addr + ADDR_W'(1);   // natural wrap at the top
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr <= '0;
    else if (load || inc) addr <= addr_d;
  end
endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave
  import sms_pkg::*;
#(
  parameter logic [6:0]  DEV_ID      = 7'h50,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              nv_busy,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              nv_start
);
  localparam logic [CNT_W-1:0] BITS_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] TX_LAST   = CNT_W'(BYTE_W - 1);

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, ev_start, ev_stop;

  sms_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .ev_start(ev_start), .ev_stop(ev_stop)
  );

  sms_state_e       state_q, state_d;
  logic [CNT_W-1:0] bitcnt_q, bitcnt_d;
  logic             oe_q, oe_d;
  logic             rw_q, rw_d;
  logic             mack_q, mack_d;
  logic             loaded_q, loaded_d;
  logic             wr_req_q, wr_req_d;
  logic             nv_start_q, nv_start_d;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [7:0]        wr_data_q;

  logic             sh_load, sh_shift;
  logic [7:0]       sh_q;
  logic             addr_load, addr_inc;
  logic [ADDR_W-1:0] addr_q;

  logic rx_state, rx_bit, rx_done, id_match;

  sms_shift8 #(.W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load_en(sh_load), .load_val(mem_rdata),
    .shift_en(sh_shift), .shift_in(sda_lvl), .q(sh_q)
  );

  sms_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(addr_load), .load_val(sh_q[ADDR_W-1:0]),
    .inc(addr_inc), .addr(addr_q)
  );

  assign rx_state = (state_q == ST_DEV) || (state_q == ST_WADR) || (state_q == ST_WDAT);
  assign rx_bit   = rx_state && scl_rise && (bitcnt_q != BITS_FULL);
  assign rx_done  = rx_state && scl_fall && (bitcnt_q == BITS_FULL);
  assign id_match = (sh_q[7:1] == DEV_ID);

  // next-state logic
  always_comb begin
    state_d    = state_q;
    bitcnt_d   = bitcnt_q;
    oe_d       = oe_q;
    rw_d       = rw_q;
    mack_d     = mack_q;
    loaded_d   = loaded_q;
    wr_req_d   = 1'b0;
    nv_start_d = 1'b0;
    sh_load    = 1'b0;
    sh_shift   = 1'b0;
    addr_load  = 1'b0;
    addr_inc   = 1'b0;

    if (ev_start) begin
      state_d  = ST_DEV;
      bitcnt_d = '0;
      oe_d     = 1'b0;
      loaded_d = 1'b0;
    end else if (ev_stop) begin
      state_d    = ST_IDLE;
      bitcnt_d   = '0;
      oe_d       = 1'b0;
      loaded_d   = 1'b0;
      nv_start_d = loaded_q;
    end else begin
      if (rx_bit) begin
        sh_shift = 1'b1;
        bitcnt_d = bitcnt_q + CNT_W'(1);
      end
      if (rx_done) bitcnt_d = '0;

      unique case (state_q)
        ST_DEV: begin
          if (rx_done) begin
            if (id_match && !nv_busy) begin
              state_d = ST_DEV_ACK;
              oe_d    = 1'b1;
              rw_d    = sh_q[0];
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        ST_DEV_ACK: begin
          if (scl_fall) begin
            if (rw_q) begin
              sh_load  = 1'b1;
              addr_inc = 1'b1;
              oe_d     = ~mem_rdata[7];
              bitcnt_d = '0;
              state_d  = ST_RDAT;
            end else begin
              oe_d    = 1'b0;
              state_d = ST_WADR;
            end
          end
        end
        ST_WADR: begin
          if (rx_done) begin
            addr_load = 1'b1;
            oe_d      = 1'b1;
            state_d   = ST_WADR_ACK;
          end
        end
        ST_WADR_ACK: begin
          if (scl_fall) begin
            oe_d    = 1'b0;
            state_d = ST_WDAT;
          end
        end
        ST_WDAT: begin
          if (rx_done) begin
            oe_d     = 1'b1;
            wr_req_d = 1'b1;
            addr_inc = 1'b1;
            loaded_d = 1'b1;
            state_d  = ST_WDAT_ACK;
          end
        end
        ST_WDAT_ACK: begin
          if (scl_fall) begin
            oe_d    = 1'b0;
            state_d = ST_WDAT;
          end
        end
        ST_RDAT: begin
          if (scl_fall) begin
            if (bitcnt_q == TX_LAST) begin
              oe_d     = 1'b0;
              bitcnt_d = '0;
              state_d  = ST_RACK;
            end else begin
              sh_shift = 1'b1;
              oe_d     = ~sh_q[6];
              bitcnt_d = bitcnt_q + CNT_W'(1);
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) mack_d = ~sda_lvl;
          if (scl_fall) begin
            if (mack_q) begin
              sh_load  = 1'b1;
              addr_inc = 1'b1;
              oe_d     = ~mem_rdata[7];
              bitcnt_d = '0;
              state_d  = ST_RDAT;
            end else begin
              state_d = ST_HOLD;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      bitcnt_q   <= '0;
      oe_q       <= 1'b0;
      rw_q       <= 1'b0;
      mack_q     <= 1'b0;
      loaded_q   <= 1'b0;
      wr_req_q   <= 1'b0;
      nv_start_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      bitcnt_q   <= bitcnt_d;
      oe_q       <= oe_d;
      rw_q       <= rw_d;
      mack_q     <= mack_d;
      loaded_q   <= loaded_d;
      wr_req_q   <= wr_req_d;
      nv_start_q <= nv_start_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else if (wr_req_d) begin
      wr_addr_q <= addr_q;
      wr_data_q <= sh_q;
    end
  end

  assign sda_oe   = oe_q;
  assign mem_addr = addr_q;
  assign wr_req   = wr_req_q;
  assign wr_addr  = wr_addr_q;
  assign wr_data  = wr_data_q;
  assign nv_start = nv_start_q;
endmodule

// File: rtl/serial_mem_slave_chk.sv
module serial_mem_slave_chk
  import sms_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sda_oe,
  input logic              scl_lvl,
  input logic              ev_start,
  input logic              ev_stop,
  input logic              nv_busy,
  input logic              nv_start,
  input logic              wr_req,
  input sms_state_e        state,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              addr_load
);
  AST_SDA_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> (!$past(scl_lvl) || $past(ev_start) || $past(ev_stop))); // R10

  AST_NO_ACK_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_DEV && state == ST_DEV_ACK) |-> !$past(nv_busy)); // R2

  AST_DRIVE_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (state != ST_IDLE)); // R1

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr != $past(mem_addr)) |-> ($past(addr_load) || (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)))); // R8

  AST_NV_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    nv_start |-> $past(ev_stop)); // R9

  AST_WR_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> ($past(state) == ST_WDAT && state == ST_WDAT_ACK)); // R9
endmodule

bind serial_mem_slave serial_mem_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_lvl(scl_lvl),
  .ev_start(ev_start), .ev_stop(ev_stop), .nv_busy(nv_busy),
  .nv_start(nv_start), .wr_req(wr_req), .state(state_q),
  .mem_addr(mem_addr), .addr_load(addr_load)
);

// File: tb/serial_mem_slave_test.sv
`timescale 1ns/1ps
module serial_mem_slave_test;
  localparam logic [6:0] ID = 7'h50;
  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda_low = 1'b0;
  logic       nv_busy = 1'b0;
  logic [7:0] mem_rdata;
  logic       sda_oe, wr_req, nv_start;
  logic [7:0] mem_addr, wr_addr, wr_data;
  wire        sda_bus = !(m_sda_low || sda_oe);

  int checks = 0, fails = 0;
  int wr_cnt = 0, nv_cnt = 0, r10_bad = 0;
  logic [7:0] last_wa, last_wd;
  logic prev_oe = 1'b0;
  int ptr = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  serial_mem_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .nv_busy(nv_busy), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .nv_start(nv_start)
  );

  function automatic logic [7:0] memf(input int a);
    logic [7:0] t;
    t = 8'((a & 255) * 37 + 11);
    return t ^ 8'h5a;
  endfunction

  always @(posedge clk) mem_rdata <= memf(int'(mem_addr));

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_req) begin wr_cnt++; last_wa = wr_addr; last_wd = wr_data; end
      if (nv_start) nv_cnt++;
      if (sda_oe != prev_oe && m_scl) r10_bad++;
    end
    prev_oe = sda_oe;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask
  task automatic bus_start(); m_sda_low = 0; tick(Q); m_scl = 1; tick(Q); m_sda_low = 1; tick(Q); m_scl = 0; tick(Q); endtask
  task automatic bus_stop(); m_sda_low = 1; tick(Q); m_scl = 1; tick(Q); m_sda_low = 0; tick(Q); endtask
  task automatic put_bit(input logic b); m_sda_low = !b; tick(Q); m_scl = 1; tick(2*Q); m_scl = 0; tick(Q); endtask
  task automatic get_bit(output logic b); m_sda_low = 0; tick(Q); m_scl = 1; tick(Q); b = sda_bus; tick(Q); m_scl = 0; tick(Q); endtask

  task automatic put_byte(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    acked = !b;
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(!give_ack);
  endtask

  // read len bytes after the read identifier, compare, then release with NACK
  task automatic read_run(input int len, input string req);
    logic [7:0] v;
    for (int i = 0; i < len; i++) begin
      get_byte(i < len - 1, v);
      check(v == memf(ptr + i), req, v, memf(ptr + i));
    end
    ptr = (ptr + len) & 255;
  endtask

  task automatic rd_current(input int len, input string req);
    logic ak;
    bus_start();
    put_byte({ID, 1'b1}, ak);
    check(ak, "R3 read id ack", ak, 1);
    read_run(len, req);
    bus_stop();
  endtask

  task automatic rd_random(input int a, input int len, input string req);
    logic ak1, ak2, ak3;
    bus_start();
    put_byte({ID, 1'b0}, ak1);
    put_byte(8'(a), ak2);
    bus_start();
    put_byte({ID, 1'b1}, ak3);
    check(ak1 && ak2 && ak3, "R5 random read acks", {ak1, ak2, ak3}, 7);
    ptr = a & 255;
    read_run(len, req);
    bus_stop();
  endtask

  task automatic set_addr(input int a);
    logic ak1, ak2;
    int w0, n0;
    w0 = wr_cnt; n0 = nv_cnt;
    bus_start();
    put_byte({ID, 1'b0}, ak1);
    put_byte(8'(a), ak2);
    bus_stop();
    tick(4);
    check(ak1 && ak2, "R6 set-address acks", {ak1, ak2}, 3);
    check(wr_cnt == w0 && nv_cnt == n0, "R6 no write or nv pulse", (wr_cnt - w0) + (nv_cnt - n0), 0);
    ptr = a & 255;
  endtask

  initial begin
    logic ak, ak2, b;
    logic [7:0] v, extra;
    int w0, n0;
    void'($urandom(32'h5eed_0042));
    tick(5);
    // R11 reset state
    check(sda_oe == 0, "R11 sda released in reset", sda_oe, 0);
    check(mem_addr == 0, "R11 counter zero", mem_addr, 0);
    check(wr_req == 0 && nv_start == 0, "R11 strobes low", {wr_req, nv_start}, 0);
    rst_n = 1'b1;
    tick(10);

    // R11 R4 first plain read comes from address 0
    rd_current(1, "R11 R4 first current read");

    // R1 foreign identifier
    bus_start();
    put_byte({7'h23, 1'b1}, ak);
    check(!ak, "R1 foreign id not acked", ak, 0);
    get_byte(1'b0, v);
    check(v == 8'hff, "R1 slave silent after foreign id", v, 8'hff);
    bus_stop();

    // R5 random read, R4 current follows, R7 sequential
    rd_random(16, 1, "R5 random read data");
    rd_current(1, "R4 current address after n");
    rd_current(4, "R7 sequential bytes");

    // R7 NACK silences slave
    bus_start();
    put_byte({ID, 1'b1}, ak);
    read_run(1, "R7 single byte");
    extra = 8'h00;
    for (int i = 7; i >= 0; i--) begin get_bit(b); extra[i] = b; end
    if (memf(ptr) != 8'hff)
      check(extra == 8'hff, "R7 no drive after NACK", extra, 8'hff);
    bus_stop();

    // R6 set address then R8 wrap
    set_addr(254);
    rd_current(3, "R8 R6 wrap after set address");
    check(ptr == 1, "R8 pointer wrapped", ptr, 1);

    // R9 write path
    w0 = wr_cnt; n0 = nv_cnt;
    bus_start();
    put_byte({ID, 1'b0}, ak);
    put_byte(8'h40, ak2);
    put_byte(8'ha5, b);
    check(ak && ak2 && b, "R9 write acks", {ak, ak2, b}, 7);
    check(last_wa == 8'h40 && last_wd == 8'ha5, "R9 first write req", {last_wa, last_wd}, 16'h40a5);
    put_byte(8'h3c, b);
    bus_stop();
    tick(4);
    check(wr_cnt - w0 == 2, "R9 write req count", wr_cnt - w0, 2);
    check(last_wa == 8'h41 && last_wd == 8'h3c, "R9 second write req", {last_wa, last_wd}, 16'h413c);
    check(nv_cnt - n0 == 1, "R9 nv pulse on stop", nv_cnt - n0, 1);
    ptr = 8'h42;

    // R2 busy polling
    nv_busy = 1'b1;
    bus_start();
    put_byte({ID, 1'b1}, ak);
    check(!ak, "R2 read id nacked while busy", ak, 0);
    bus_stop();
    w0 = wr_cnt;
    bus_start();
    put_byte({ID, 1'b0}, ak);
    check(!ak, "R2 write id nacked while busy", ak, 0);
    put_byte(8'h10, ak);
    put_byte(8'h77, ak);
    bus_stop();
    tick(4);
    check(wr_cnt == w0, "R2 no write while busy", wr_cnt - w0, 0);
    nv_busy = 1'b0;
    rd_current(1, "R2 R4 ack and data after busy clears");

    // random mix
    for (int it = 0; it < 24; it++) begin
      int op, a, len;
      op  = int'($urandom % 3);
      a   = int'($urandom % 256);
      len = 1 + int'($urandom % 4);
      case (op)
        0: rd_random(a, len, "R5 R7 R8 random read");
        1: rd_current(len, "R4 R7 R8 current read");
        default: set_addr(a);
      endcase
    end

    check(r10_bad == 0, "R10 sda changes only with scl low", r10_bad, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule